// File: doc/BRIEF.md
# Dual-Port Semaphore Flag Bank

This block is a small bank of binary token flags that two independent ports, called left and right, share. Each flag is a token that at most one side holds at any time. The flags do not gate any other hardware. Software on either side gives them meaning, so no access to the bank ever stalls.

A side claims a flag by writing a 0 to it and then reads the flag back to learn whether the claim succeeded. It gives the flag up by writing a 1. When a side asks for a flag that the other side holds, the request is kept as pending. The token then moves to the waiting side at the same clock edge that captures the holder's release. A waiting side cancels its pending request by writing a 1. The bank has its own address space, reached only while the port's active-low semaphore select is driven low. Address, output enable and write enable then work as they would for an ordinary memory. Writes are taken on the rising clock edge. Reads are combinational from the current flag state.

Top module: `sem_bank`

## Requirements
- R1: After the asynchronous reset, every flag is free and no request is pending. A read of any flag from either side returns all ones.
- R2: A port accesses the bank only while its select `sem_n` is low. With select high, a write changes nothing and the read data is all ones. A read needs select low, `oe_n` low and `we_n` high, and otherwise returns all ones.
- R3: A write of 0 (data bit 0 = 0) to a free flag gives that side ownership after the capturing clock edge.
- R4: A read returns 0 on every data bit when the reading side owns the addressed flag, and all ones otherwise. All data bits always equal bit 0.
- R5: Both sides never own the same flag at once.
- R6: A write of 1 by the owning side frees the flag when no request from the other side is pending.
- R7: A write of 1 by a side that does not own the flag leaves the other side's ownership unchanged.
- R8: A write of 0 to a flag that the other side owns is latched as pending and gives no ownership. When the owner releases the flag, the waiting side owns it right after the release edge.
- R9: A write of 1 by a waiting side cancels its pending request, so a later release by the owner leaves the flag free.
- R10: When both sides write 0 to the same free flag in the same cycle, the left side wins and the right side's request stays pending.
- R11: Each flag is independent. An access to one address changes no other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; writes are captured on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sem_n_i | input | 1 | Left semaphore select, active low |
| l_addr_i | input | ADDR_W | Left flag address |
| l_we_n_i | input | 1 | Left write enable, active low |
| l_oe_n_i | input | 1 | Left output enable, active low |
| l_wdata_i | input | 1 | Left write data bit (0 = request, 1 = release) |
| l_rdata_o | output | DATA_W | Left read data |
| r_sem_n_i | input | 1 | Right semaphore select, active low |
| r_addr_i | input | ADDR_W | Right flag address |
| r_we_n_i | input | 1 | Right write enable, active low |
| r_oe_n_i | input | 1 | Right output enable, active low |
| r_wdata_i | input | 1 | Right write data bit (0 = request, 1 = release) |
| r_rdata_o | output | DATA_W | Right read data |

## Verification
The bench builds the bank with its default values: eight flags, a 3-bit address and 16-bit read data. At this size every address can be reached from both ports, and the bench can check that all sixteen read bits follow bit 0. The default size also lets one flag's handoff, withdrawal or same-cycle tie run while a neighbouring flag is watched for leakage. The directed scenarios drive the pending-request path through every outcome: a handoff on release, a cancellation before the release, and a tie won by the left side.

// File: rtl/sem_pkg.sv
package sem_pkg;
  typedef enum logic [1:0] {
    OWN_NONE  = 2'd0,
    OWN_LEFT  = 2'd1,
    OWN_RIGHT = 2'd2
  } owner_e;
endpackage

// File: rtl/sem_port.sv
module sem_port #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input  logic                 sem_n_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_n_i,
  input  logic                 oe_n_i,
  input  logic                 wdata_i,
  input  logic [NUM_FLAGS-1:0] own_i,
  output logic [NUM_FLAGS-1:0] req_o,
  output logic [NUM_FLAGS-1:0] rel_o,
  output logic [DATA_W-1:0]    rdata_o
);
  logic wr_en, rd_en, in_range;
  logic [NUM_FLAGS-1:0] sel;

  assign in_range = 32'(addr_i) < NUM_FLAGS;
  assign wr_en    = !sem_n_i && !we_n_i && in_range;
  assign rd_en    = !sem_n_i && we_n_i && !oe_n_i && in_range;
  assign sel      = NUM_FLAGS'(1) << addr_i;

  assign req_o = (wr_en && !wdata_i) ? sel : '0;
  assign rel_o = (wr_en &&  wdata_i) ? sel : '0;

  // active-low token: 0 means the reader holds it
  assign rdata_o = rd_en ? {DATA_W{~|(own_i & sel)}} : '1;
endmodule

// File: rtl/sem_flag.sv
module sem_flag
  import sem_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_l_i,
  input  logic rel_l_i,
  input  logic req_r_i,
  input  logic rel_r_i,
  output logic own_l_o,
  output logic own_r_o
);
  owner_e owner_q, owner_d;
  logic   pend_l_q, pend_r_q, pend_l_d, pend_r_d;
  logic   want_l, want_r;

  // a release write also withdraws a pending request from that side
  assign want_l = (pend_l_q | req_l_i) & ~rel_l_i;
  assign want_r = (pend_r_q | req_r_i) & ~rel_r_i;

  always_comb begin
    owner_d = owner_q;
    unique case (owner_q)
      OWN_NONE: begin
        if (want_l)      owner_d = OWN_LEFT;
        else if (want_r) owner_d = OWN_RIGHT;
      end
      OWN_LEFT:  if (rel_l_i) owner_d = want_r ? OWN_RIGHT : OWN_NONE;
      OWN_RIGHT: if (rel_r_i) owner_d = want_l ? OWN_LEFT  : OWN_NONE;
      default:   owner_d = OWN_NONE;
    endcase
    pend_l_d = want_l && (owner_d != OWN_LEFT);
    pend_r_d = want_r && (owner_d != OWN_RIGHT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q  <= OWN_NONE;
      pend_l_q <= 1'b0;
      pend_r_q <= 1'b0;
    end else begin
      owner_q  <= owner_d;
      pend_l_q <= pend_l_d;
      pend_r_q <= pend_r_d;
    end
  end

  assign own_l_o = (owner_q == OWN_LEFT);
  assign own_r_o = (owner_q == OWN_RIGHT);
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  localparam int ADDR_W   = (NUM_FLAGS > 1) ? $clog2(NUM_FLAGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              l_sem_n_i,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_n_i,
  input  logic              l_oe_n_i,
  input  logic              l_wdata_i,
  output logic [DATA_W-1:0] l_rdata_o,
  input  logic              r_sem_n_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_n_i,
  input  logic              r_oe_n_i,
  input  logic              r_wdata_i,
  output logic [DATA_W-1:0] r_rdata_o
);
  logic [NUM_FLAGS-1:0] req_l, rel_l, req_r, rel_r, own_l, own_r;

  sem_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_l (
    .sem_n_i(l_sem_n_i), .addr_i(l_addr_i), .we_n_i(l_we_n_i), .oe_n_i(l_oe_n_i),
    .wdata_i(l_wdata_i), .own_i(own_l), .req_o(req_l), .rel_o(rel_l),
    .rdata_o(l_rdata_o)
  );

  sem_port #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_port_r (
    .sem_n_i(r_sem_n_i), .addr_i(r_addr_i), .we_n_i(r_we_n_i), .oe_n_i(r_oe_n_i),
    .wdata_i(r_wdata_i), .own_i(own_r), .req_o(req_r), .rel_o(rel_r),
    .rdata_o(r_rdata_o)
  );

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    sem_flag u_flag (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .req_l_i(req_l[g]), .rel_l_i(rel_l[g]),
      .req_r_i(req_r[g]), .rel_r_i(rel_r[g]),
      .own_l_o(own_l[g]), .own_r_o(own_r[g])
    );
  end
endmodule

// File: rtl/sem_bank_chk.sv
module sem_bank_chk #(
  parameter int NUM_FLAGS = 8,
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 3
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 l_sem_n_i,
  input logic [ADDR_W-1:0]    l_addr_i,
  input logic                 l_we_n_i,
  input logic                 l_wdata_i,
  input logic [DATA_W-1:0]    l_rdata_o,
  input logic                 r_sem_n_i,
  input logic [ADDR_W-1:0]    r_addr_i,
  input logic                 r_we_n_i,
  input logic                 r_wdata_i,
  input logic [NUM_FLAGS-1:0] own_l,
  input logic [NUM_FLAGS-1:0] own_r
);
  logic l_wr0, l_wr1, r_wr_any_same;
  assign l_wr0 = !l_sem_n_i && !l_we_n_i && !l_wdata_i;
  assign l_wr1 = !l_sem_n_i && !l_we_n_i &&  l_wdata_i;
  assign r_wr_any_same = !r_sem_n_i && !r_we_n_i && (r_addr_i == l_addr_i);

  // R5
  excl_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_l & own_r) == '0);

  // R4
  rdata_fanout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_rdata_o == {DATA_W{l_rdata_o[0]}});

  // R2
  desel_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_sem_n_i |-> (l_rdata_o == '1));

  // R3
  grab_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr0 && !own_l[l_addr_i] && !own_r[l_addr_i]) |=> own_l[$past(l_addr_i)]);

  // R7
  foreign_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr1 && own_r[l_addr_i] && !r_wr_any_same) |=> own_r[$past(l_addr_i)]);

  // R6
  owner_rel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr1 && own_l[l_addr_i]) |=> !own_l[$past(l_addr_i)]);

  // R8
  held_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (l_wr0 && own_r[l_addr_i] && !r_wr_any_same) |=> !own_l[$past(l_addr_i)]);
endmodule

bind sem_bank sem_bank_chk #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .l_sem_n_i(l_sem_n_i), .l_addr_i(l_addr_i), .l_we_n_i(l_we_n_i),
  .l_wdata_i(l_wdata_i), .l_rdata_o(l_rdata_o),
  .r_sem_n_i(r_sem_n_i), .r_addr_i(r_addr_i), .r_we_n_i(r_we_n_i),
  .r_wdata_i(r_wdata_i), .own_l(own_l), .own_r(own_r)
);

// File: tb/sem_bank_test.sv
module sem_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_FLAGS  = 8;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 3;
  localparam logic [DATA_W-1:0] HELD = '0;
  localparam logic [DATA_W-1:0] NOT_HELD = '1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic l_sem_n = 1'b1, l_we_n = 1'b1, l_oe_n = 1'b1, l_wd = 1'b1;
  logic r_sem_n = 1'b1, r_we_n = 1'b1, r_oe_n = 1'b1, r_wd = 1'b1;
  logic [ADDR_W-1:0] l_addr = '0, r_addr = '0;
  logic [DATA_W-1:0] l_rd, r_rd;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sem_bank #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .l_sem_n_i(l_sem_n), .l_addr_i(l_addr), .l_we_n_i(l_we_n), .l_oe_n_i(l_oe_n),
    .l_wdata_i(l_wd), .l_rdata_o(l_rd),
    .r_sem_n_i(r_sem_n), .r_addr_i(r_addr), .r_we_n_i(r_we_n), .r_oe_n_i(r_oe_n),
    .r_wdata_i(r_wd), .r_rdata_o(r_rd)
  );

  task automatic chk(string req, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    l_sem_n = 1'b1; l_we_n = 1'b1; l_oe_n = 1'b1; l_wd = 1'b1;
    r_sem_n = 1'b1; r_we_n = 1'b1; r_oe_n = 1'b1; r_wd = 1'b1;
  endtask

  // one write cycle; side 0 = left, 1 = right; driven at negedge
  task automatic wr(bit side, int a, bit d);
    if (!side) begin l_sem_n = 0; l_we_n = 0; l_addr = ADDR_W'(a); l_wd = d; end
    else       begin r_sem_n = 0; r_we_n = 0; r_addr = ADDR_W'(a); r_wd = d; end
    @(negedge clk);
    idle();
  endtask

  task automatic wr_both(int a, bit dl, bit dr);
    l_sem_n = 0; l_we_n = 0; l_addr = ADDR_W'(a); l_wd = dl;
    r_sem_n = 0; r_we_n = 0; r_addr = ADDR_W'(a); r_wd = dr;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(bit side, int a, output logic [DATA_W-1:0] v);
    if (!side) begin l_sem_n = 0; l_oe_n = 0; l_addr = ADDR_W'(a); end
    else       begin r_sem_n = 0; r_oe_n = 0; r_addr = ADDR_W'(a); end
    #1;
    v = side ? r_rd : l_rd;
    idle();
    #1;
  endtask

  task automatic t_reset();
    logic [DATA_W-1:0] v;
    for (int a = 0; a < NUM_FLAGS; a++) begin
      rd(0, a, v); chk("R1 left reset read", v, NOT_HELD);
      rd(1, a, v); chk("R1 right reset read", v, NOT_HELD);
    end
  endtask

  task automatic t_deselect();
    logic [DATA_W-1:0] v;
    l_sem_n = 1; l_we_n = 0; l_addr = 2; l_wd = 0;
    @(negedge clk); idle();
    rd(0, 2, v); chk("R2 deselected write ignored", v, NOT_HELD);
    wr(0, 2, 0);
    l_sem_n = 1; l_oe_n = 0; l_addr = 2; #1;
    chk("R2 read with select high", l_rd, NOT_HELD);
    l_sem_n = 0; l_we_n = 0; #1;
    chk("R2 read blocked while write enabled", l_rd, NOT_HELD);
    idle(); #1;
    rd(0, 2, v); chk("R2 owner read after select", v, HELD);
    wr(0, 2, 1);
  endtask

  task automatic t_handoff();
    logic [DATA_W-1:0] v;
    wr(0, 0, 0);
    rd(0, 0, v); chk("R3 left claims free flag", v, HELD);
    rd(1, 0, v); chk("R4 non-owner read", v, NOT_HELD);
    wr(1, 0, 0);
    rd(1, 0, v); chk("R8 request on held flag not granted", v, NOT_HELD);
    rd(0, 0, v); chk("R5 holder keeps flag", v, HELD);
    wr(0, 0, 1);
    rd(1, 0, v); chk("R8 waiting side granted on release", v, HELD);
    rd(0, 0, v); chk("R8 releaser no longer owns", v, NOT_HELD);
    wr(1, 0, 1);
    rd(1, 0, v); chk("R6 owner release frees flag", v, NOT_HELD);
    rd(0, 0, v); chk("R6 flag free for left", v, NOT_HELD);
  endtask

  task automatic t_foreign_release();
    logic [DATA_W-1:0] v;
    wr(0, 3, 0);
    wr(1, 3, 1);
    rd(0, 3, v); chk("R7 non-owner release ignored", v, HELD);
    wr(0, 3, 1);
  endtask

  task automatic t_withdraw();
    logic [DATA_W-1:0] v;
    wr(0, 4, 0);
    wr(1, 4, 0);
    wr(1, 4, 1);
    wr(0, 4, 1);
    rd(1, 4, v); chk("R9 withdrawn request not granted", v, NOT_HELD);
    rd(0, 4, v); chk("R9 flag left free", v, NOT_HELD);
  endtask

  task automatic t_tie();
    logic [DATA_W-1:0] v;
    wr_both(5, 0, 0);
    rd(0, 5, v); chk("R10 left wins tie", v, HELD);
    rd(1, 5, v); chk("R10 right loses tie", v, NOT_HELD);
    wr(0, 5, 1);
    rd(1, 5, v); chk("R10 right pending kept after tie", v, HELD);
    wr(1, 5, 1);
  endtask

  task automatic t_independent();
    logic [DATA_W-1:0] v;
    wr(0, 6, 0);
    rd(0, 7, v); chk("R11 neighbour untouched", v, NOT_HELD);
    wr(1, 7, 0);
    rd(1, 7, v); chk("R11 right claims neighbour", v, HELD);
    rd(0, 6, v); chk("R11 left flag kept", v, HELD);
    wr(0, 6, 1); wr(1, 7, 1);
    rd(0, 6, v); chk("R11 cleanup", v, NOT_HELD);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_deselect();
    t_handoff();
    t_foreign_release();
    t_withdraw();
    t_tie();
    t_independent();
    @(negedge clk);
    finish_run();
  end
endmodule